// File: doc/BRIEF.md
# Constant On-Time Pulse Generator

This block produces the high-side switch command for a ripple-regulated buck controller built around a fixed on-time. An upstream comparator reports, as a single flag, that the sensed feedback sits below whichever is lower of the soft-start level and the reference. When that flag is seen, the block raises its switch command for a programmed number of clock cycles. It then holds the command low for a fixed minimum interval before any further pulse is allowed. Because pulses come from feedback events and not from a timebase, the switching rate follows the load.

The on-time is supplied as a cycle count and is captured when each pulse starts. A count of zero disables pulsing. A run enable gates the output at once and cuts short any pulse in progress. A one-cycle strobe marks the first cycle of every pulse, so that downstream logic can count switching cycles.

The control is a three-state machine:
- IDLE waits for a trigger.
- ON times the pulse.
- OFF times the enforced low interval.

The transitions are:
- IDLE→ON on a trigger (start).
- ON→OFF when the on-time expires or run drops (end or abort).
- OFF→ON when the low interval expires with the trigger already present (back-to-back).
- OFF→IDLE when the interval expires with no trigger (settle).

Top module: `cot_pulse_gen`

## Requirements
- R1: In IDLE, when run_en is high, on_count is non-zero and fb_below is high at a rising clock edge, pwm is high in the cycle after that edge.
- R2: pwm stays high for exactly the on_count value captured at the start edge. Changes to on_count or fb_below while the pulse is running have no effect on its width.
- R3: After pwm falls it stays low for at least MIN_OFF cycles (default 40). A trigger that appears and disappears inside that window produces no pulse.
- R4: While fb_below stays low, no pulse is issued, whatever the other inputs are.
- R5: While run_en is low, pwm and pulse_start are low in that same cycle and a running pulse is aborted. The minimum low interval still applies after an abort.
- R6: When on_count is zero, no pulse starts even with fb_below held high.
- R7: pulse_start is high for exactly one cycle per pulse, namely the first cycle in which pwm is high.
- R8: With fb_below held high, the next pulse starts in the first cycle after the low interval expires, so pwm is low for exactly MIN_OFF cycles between pulses.
- R9: During and right after reset, pwm and pulse_start are low and the machine is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run enable; low forces the output off |
| fb_below | input | 1 | Feedback-below-threshold flag from the comparator |
| on_count | input | ON_W (10) | On-time in clock cycles; zero suppresses pulses |
| pwm | output | 1 | High-side switch command |
| pulse_start | output | 1 | One-cycle strobe on the first cycle of each pulse |

## Verification
The bench measures the exact low interval between two pulses with the trigger held high. A machine that returned through IDLE first would show 41 cycles instead of 40, and one that dropped the interval would show far fewer. It changes on_count and toggles fb_below partway through a pulse, which exposes a design that reads the count live or lets feedback end the pulse early. It drops run_en mid-pulse and samples in the same cycle, which catches a registered gate that lags by one cycle, and then checks that the following pulse still honours the low interval. A zero count, a one-cycle count, and a trigger that vanishes before the interval expires cover the remaining boundaries.

// File: rtl/cot_pkg.sv
package cot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } cot_state_e;
endpackage

// File: rtl/cot_loadcnt.sv
// Loadable down-counter that flags when it has reached zero.
module cot_loadcnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/cot_trigger.sv
// Qualifies the comparator flag into a pulse request.
module cot_trigger #(
    parameter int ON_W = 10
) (
    input  logic            run_en,
    input  logic            fb_below,
    input  logic [ON_W-1:0] on_count,
    output logic            fire
);
    assign fire = run_en && fb_below && (on_count != '0);
endmodule

// File: rtl/cot_pulse_gen.sv
module cot_pulse_gen #(
    parameter int ON_W    = 10,
    parameter int MIN_OFF = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic            fb_below,
    input  logic [ON_W-1:0] on_count,
    output logic            pwm,
    output logic            pulse_start
);
    import cot_pkg::*;

    localparam int OFF_W = $clog2(MIN_OFF) + 1;
    localparam logic [OFF_W-1:0] OFF_RELOAD = OFF_W'(MIN_OFF - 1);

    cot_state_e state_q, state_d;
    logic       first_q;
    logic       fire;
    logic       on_load, on_dec, on_zero;
    logic       off_load, off_dec, off_zero;
    logic [ON_W-1:0] on_reload;

    assign on_reload = on_count - 1'b1;

    cot_trigger #(.ON_W(ON_W)) u_trig (
        .run_en   (run_en),
        .fb_below (fb_below),
        .on_count (on_count),
        .fire     (fire)
    );

    cot_loadcnt #(.W(ON_W)) u_on_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (on_load),
        .load_val (on_reload),
        .dec      (on_dec),
        .zero     (on_zero)
    );

    cot_loadcnt #(.W(OFF_W)) u_off_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (off_load),
        .load_val (OFF_RELOAD),
        .dec      (off_dec),
        .zero     (off_zero)
    );

    // Next state and timer controls
    always_comb begin
        state_d  = state_q;
        on_load  = 1'b0;
        on_dec   = 1'b0;
        off_load = 1'b0;
        off_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fire) begin
                    state_d = ST_ON;
                    on_load = 1'b1;
                end
            end
            ST_ON: begin
                if (!run_en || on_zero) begin
                    state_d  = ST_OFF;
                    off_load = 1'b1;
                end else begin
                    on_dec = 1'b1;
                end
            end
            ST_OFF: begin
                if (off_zero) begin
                    if (fire) begin
                        state_d = ST_ON;
                        on_load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    off_dec = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            first_q <= on_load;
        end
    end

    // Outputs
    always_comb begin
        pwm         = (state_q == ST_ON) && run_en;
        pulse_start = pwm && first_q;
    end
endmodule

// File: rtl/cot_pulse_gen_chk.sv
module cot_pulse_gen_chk #(
    parameter int ON_W    = 10,
    parameter int MIN_OFF = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic            fb_below,
    input logic [ON_W-1:0] on_count,
    input logic            pwm,
    input logic            pulse_start
);
    localparam int LW = $clog2(MIN_OFF) + 2;

    logic            pwm_q;
    logic [LW-1:0]   low_cnt;
    logic [ON_W:0]   hi_cnt;
    logic [ON_W-1:0] cnt_q;
    logic [ON_W:0]   width_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q   <= 1'b0;
            low_cnt <= LW'(MIN_OFF);
            hi_cnt  <= '0;
            cnt_q   <= '0;
            width_q <= '0;
        end else begin
            pwm_q <= pwm;
            cnt_q <= on_count;
            if (pwm)
                low_cnt <= '0;
            else if (low_cnt < LW'(MIN_OFF))
                low_cnt <= low_cnt + 1'b1;
            if (pwm)
                hi_cnt <= pwm_q ? hi_cnt + 1'b1 : (ON_W+1)'(1);
            if (pulse_start)
                width_q <= {1'b0, cnt_q};
        end
    end

    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> (pwm && !pwm_q));                                   // R7
    AST_RISE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !pwm_q) |-> pulse_start);                                   // R7
    AST_RUN_GATES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!pwm && !pulse_start));                                // R5
    AST_MIN_OFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !pwm_q) |-> (low_cnt >= LW'(MIN_OFF)));                     // R3
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> ($past(fb_below) && $past(run_en) && $past(on_count) != '0)); // R1
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_q && !pwm && run_en) |-> (hi_cnt == width_q));                 // R2
endmodule

bind cot_pulse_gen cot_pulse_gen_chk #(.ON_W(ON_W), .MIN_OFF(MIN_OFF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .fb_below    (fb_below),
    .on_count    (on_count),
    .pwm         (pwm),
    .pulse_start (pulse_start)
);

// File: tb/test_cot_pulse_gen.sv
module test_cot_pulse_gen;
    localparam int CLK_PERIOD = 10;
    localparam int ON_W       = 10;
    localparam int MIN_OFF    = 40;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            run_en;
    logic            fb_below;
    logic [ON_W-1:0] on_count;
    logic            pwm;
    logic            pulse_start;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cot_pulse_gen #(.ON_W(ON_W), .MIN_OFF(MIN_OFF)) i_cot_pulse_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .fb_below    (fb_below),
        .on_count    (on_count),
        .pwm         (pwm),
        .pulse_start (pulse_start)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic measure_high(output int n, output int starts);
        n = 0;
        starts = 0;
        while (pwm && n < 5000) begin
            n++;
            if (pulse_start) starts++;
            step();
        end
    endtask

    task automatic measure_low(output int n);
        n = 0;
        while (!pwm && n < 5000) begin
            n++;
            step();
        end
    endtask

    task automatic quiet(input int cyc, output int hi);
        hi = 0;
        for (int i = 0; i < cyc; i++) begin
            step();
            if (pwm || pulse_start) hi++;
        end
    endtask

    task automatic drain();
        int hi;
        fb_below = 1'b0;
        run_en   = 1'b1;
        quiet(MIN_OFF + 5, hi);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b1; fb_below = 1'b1; on_count = 10'd20;
        repeat (3) step();
        chk(pwm == 1'b0, "R9 pwm in reset", pwm, 0);
        chk(pulse_start == 1'b0, "R9 strobe in reset", pulse_start, 0);
        fb_below = 1'b0;
        rst_n = 1'b1;
        step();
        chk(pwm == 1'b0 && pulse_start == 1'b0, "R9 after reset", pwm, 0);
    endtask

    task automatic t_basic();
        int n, s;
        on_count = 10'd25;
        fb_below = 1'b1;
        step();
        chk(pwm == 1'b1, "R1 pwm rises one cycle after trigger", pwm, 1);
        chk(pulse_start == 1'b1, "R7 strobe on first cycle", pulse_start, 1);
        fb_below = 1'b0;
        measure_high(n, s);
        chk(n == 25, "R2 width 25", n, 25);
        chk(s == 1, "R7 one strobe per pulse", s, 1);
        drain();
    endtask

    task automatic t_held();
        int n, s, lo;
        on_count = 10'd10;
        fb_below = 1'b1;
        step();
        measure_high(n, s);
        chk(n == 10, "R2 width 10", n, 10);
        measure_low(lo);
        chk(lo == MIN_OFF, "R8 held trigger gap", lo, MIN_OFF);
        chk(lo >= MIN_OFF, "R3 minimum low interval", lo, MIN_OFF);
        chk(pulse_start == 1'b1, "R7 strobe on back-to-back pulse", pulse_start, 1);
        fb_below = 1'b0;
        measure_high(n, s);
        chk(n == 10, "R2 second width 10", n, 10);
        drain();
    endtask

    task automatic t_prebias();
        int hi;
        on_count = 10'd30;
        fb_below = 1'b0;
        quiet(200, hi);
        chk(hi == 0, "R4 no pulse while feedback high", hi, 0);
    endtask

    task automatic t_zero_count();
        int hi;
        on_count = 10'd0;
        fb_below = 1'b1;
        quiet(100, hi);
        chk(hi == 0, "R6 zero count suppresses", hi, 0);
        drain();
    endtask

    task automatic t_midpulse_changes();
        int n, s;
        on_count = 10'd30;
        fb_below = 1'b1;
        step();
        fb_below = 1'b0;
        step();
        on_count = 10'd5;
        fb_below = 1'b1;
        step();
        fb_below = 1'b0;
        step();
        measure_high(n, s);
        chk(n + 3 == 30, "R2 width ignores mid-pulse changes", n + 3, 30);
        drain();
    endtask

    task automatic t_one_cycle();
        int n, s;
        on_count = 10'd1;
        fb_below = 1'b1;
        step();
        fb_below = 1'b0;
        measure_high(n, s);
        chk(n == 1, "R2 one-cycle width", n, 1);
        chk(s == 1, "R7 strobe on one-cycle pulse", s, 1);
        drain();
    endtask

    task automatic t_transient_trigger();
        int n, s, hi;
        on_count = 10'd8;
        fb_below = 1'b1;
        step();
        fb_below = 1'b0;
        measure_high(n, s);
        repeat (5) step();
        fb_below = 1'b1;
        repeat (3) step();
        fb_below = 1'b0;
        quiet(MIN_OFF + 10, hi);
        chk(hi == 0, "R3 brief trigger inside window ignored", hi, 0);
    endtask

    task automatic t_abort();
        int n, s, hi, lo;
        on_count = 10'd50;
        fb_below = 1'b1;
        step();
        repeat (5) step();
        chk(pwm == 1'b1, "R1 pulse running before abort", pwm, 1);
        run_en = 1'b0;
        #1;
        chk(pwm == 1'b0, "R5 pwm drops in same cycle", pwm, 0);
        lo = 1;
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            lo++;
            if (pwm || pulse_start) hi++;
        end
        chk(hi == 0, "R5 no pulse while run low", hi, 0);
        run_en = 1'b1;
        step();
        measure_low(n);
        lo = lo + n;
        chk(lo >= MIN_OFF, "R5 low interval after abort", lo, MIN_OFF);
        chk(pulse_start == 1'b1, "R7 strobe after abort", pulse_start, 1);
        fb_below = 1'b0;
        measure_high(n, s);
        chk(n == 50, "R2 full width after abort", n, 50);
        drain();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_held();
        t_prebias();
        t_zero_count();
        t_midpulse_changes();
        t_one_cycle();
        t_transient_trigger();
        t_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule